// File: doc/BRIEF.md
# Serial ADC Output Shifter Model

This block models the digital half of a sampling converter's serial port. It runs on a fast system clock. The chip-select and serial-clock pins arrive as asynchronous inputs, and the block finds their edges internally. When chip-select falls, the block captures a parallel sample word and shifts it out on a single data pin. The data pin has an output-enable, so it can share a three-state bus.

Every frame has the same shape: two leading zeros, then the sample MSB first, then trailing zeros up to sixteen slots. The first leading zero appears on the chip-select edge itself. Every later bit appears on a serial-clock falling edge.

A hold flag shows when the modelled track-and-hold is holding the captured value. The flag returns to track after the conversion window, which is the resolution plus two serial-clock cycles. If chip-select rises early, the frame is abandoned. With 8-bit resolution, an early rise also puts the part into power-down, and a power-down flag reports it. Resolution is a parameter and may be 12, 10 or 8.

Top module: `adc_serial_port`

## Requirements
- R1: The first chip-select falling edge seen after reset or after a frame ends has four effects. The output-enable turns on, the data pin drives 0 (the first leading zero), the hold flag is set and the sample word is captured. Each of these appears on the third system clock edge after the pin changes.
- R2: Falling serial-clock edges 1 to RES+1 of the frame each put out one bit. Edge 1 gives the second leading zero. Edges 2 to RES+1 give the captured sample, from bit RES-1 down to bit 0.
- R3: Falling edges RES+2 to 15 drive 0 as trailing zeros. There are 2 of them at 12 bits, 4 at 10 bits and 6 at 8 bits.
- R4: The 16th falling serial-clock edge of a frame turns the output-enable off. Further falling edges before chip-select rises leave it off.
- R5: The hold flag clears on the first rising serial-clock edge that follows the (RES+1)th falling edge. Before that edge it stays set.
- R6: A chip-select rise at any point turns the output-enable off and resets the slot count. The next frame therefore starts again from the first leading zero.
- R7: A chip-select rise while the hold flag is still set aborts the conversion and clears the hold flag. The power-down flag is set by this rise if and only if RES is 8. A rise after the hold flag has cleared never sets power-down.
- R8: The power-down flag clears on the next chip-select falling edge.
- R9: A change on the sample input after the chip-select falling edge has no effect on the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sample_in | input | RES | Parallel sample word, captured when chip-select falls |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the data pin; 0 means high impedance |
| hold_o | output | 1 | 1 while the sample is held, 0 while tracking |
| pdown_o | output | 1 | Power-down flag |

## Verification
The bench runs three copies of the block, at 12, 10 and 8 bits, side by side. It sweeps every slot of full frames over walking-one and patterned samples. A design whose data is off by one slot, or that misses the chip-select-driven first zero, fails on the bit checks. A design with the wrong trailing-zero count, or one that keeps driving after the 16th edge, fails at the frame end.

Early chip-select rises are swept over every serial-clock count from 0 to 16. This catches a hold flag that clears one cycle early or late, power-down raised at the wrong resolution or after a completed conversion, and a slot count that survives an abort. The sample input is inverted mid-frame, so a design that samples it live rather than at the chip-select edge also fails.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
   localparam int FRAME_SLOTS = 16;
   localparam int LEAD_ZEROS  = 2;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/adc_sp_edge.sv
module adc_sp_edge
   import adc_sp_pkg::*;
#(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_sp_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign ev.rise = chain[STAGES-1] & ~chain[STAGES];
   assign ev.fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/adc_sp_shift.sv
module adc_sp_shift #(
   parameter int RES   = 12,
   parameter int FRAME = 16,
   parameter int LEAD  = 2,
   localparam int CW   = $clog2(FRAME + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           shift,
   input  logic           clear,
   input  logic [RES-1:0] sample,
   output logic           sdata,
   output logic           oe,
   output logic [CW-1:0]  slot
);
   if (LEAD + RES > FRAME) begin : g_bad_fit
      $error("adc_sp_shift: frame too short for resolution");
   end

   logic [FRAME-1:0] word;
   logic [FRAME-1:0] sr;

   always_comb begin
      word = '0;
      word[FRAME-1-LEAD -: RES] = sample;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         oe   <= 1'b0;
         slot <= '0;
      end else if (clear) begin
         oe   <= 1'b0;
         slot <= '0;
      end else if (load) begin
         sr   <= word;
         oe   <= 1'b1;
         slot <= '0;
      end else if (shift && oe) begin
         sr   <= {sr[FRAME-2:0], 1'b0};
         slot <= slot + 1'b1;
         if (slot == CW'(FRAME - 1)) oe <= 1'b0;
      end
   end

   assign sdata = sr[FRAME-1];
endmodule

// File: rtl/adc_sp_ctrl.sv
module adc_sp_ctrl #(
   parameter int RES = 12,
   parameter int CW  = 5,
   localparam int NCYC = RES + 2,
   localparam bit PD_ON_ABORT = (RES == 8)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_fall,
   input  logic          cs_rise,
   input  logic          sclk_rise,
   input  logic [CW-1:0] slot,
   output logic          hold,
   output logic          pdown
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         hold <= 1'b0;
      else if (cs_rise)                                   hold <= 1'b0;
      else if (cs_fall)                                   hold <= 1'b1;
      else if (sclk_rise && (slot >= CW'(NCYC - 1)))      hold <= 1'b0;
   end

   if (PD_ON_ABORT) begin : g_pd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pdown <= 1'b0;
         else if (cs_rise && hold)  pdown <= 1'b1;
         else if (cs_fall)          pdown <= 1'b0;
      end
   end else begin : g_no_pd
      assign pdown = 1'b0;
   end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adc_sp_pkg::*;
#(
   parameter int RES         = 12,
   parameter int SYNC_STAGES = 2,
   localparam int CW         = $clog2(FRAME_SLOTS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           sclk,
   input  logic [RES-1:0] sample_in,
   output logic           sdata_o,
   output logic           sdata_oe,
   output logic           hold_o,
   output logic           pdown_o
);
   if (!(RES == 8 || RES == 10 || RES == 12)) begin : g_bad_res
      $error("adc_serial_port: RES must be 8, 10 or 12");
   end

   edge_t         cs_ev, sclk_ev;
   logic          cs_fall, cs_rise, sclk_fall, sclk_rise;
   logic [CW-1:0] slot;

   adc_sp_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .ev(cs_ev));

   adc_sp_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .din(sclk), .ev(sclk_ev));

   assign cs_fall   = cs_ev.fall;
   assign cs_rise   = cs_ev.rise;
   assign sclk_fall = sclk_ev.fall;
   assign sclk_rise = sclk_ev.rise;

   adc_sp_shift #(.RES(RES), .FRAME(FRAME_SLOTS), .LEAD(LEAD_ZEROS)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load(cs_fall), .shift(sclk_fall), .clear(cs_rise),
      .sample(sample_in),
      .sdata(sdata_o), .oe(sdata_oe), .slot(slot));

   adc_sp_ctrl #(.RES(RES), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
      .slot(slot), .hold(hold_o), .pdown(pdown_o));
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_fall,
   input logic cs_rise,
   input logic sclk_rise,
   input logic sdata_o,
   input logic sdata_oe,
   input logic hold_o,
   input logic pdown_o
);
   AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall && !cs_rise |=> sdata_oe && !sdata_o && hold_o); // R1
   AST_OE_FROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe) |-> $past(cs_fall)); // R1
   AST_TRACK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> $past(sclk_rise) || $past(cs_rise)); // R5
   AST_CS_RISE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdata_oe); // R6
   AST_ABORT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !hold_o); // R7
   AST_PD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdown_o) |-> $past(cs_rise) && $past(hold_o)); // R7
   AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall && !cs_rise |=> !pdown_o); // R8
endmodule

bind adc_serial_port adc_sp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
   .sclk_rise(sclk_rise), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
   .hold_o(hold_o), .pdown_o(pdown_o));

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [11:0] smp = '0;
   logic [2:0]  so, oe, hd, pd;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_serial_port #(.RES(12)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(smp),
      .sdata_o(so[0]), .sdata_oe(oe[0]), .hold_o(hd[0]), .pdown_o(pd[0]));
   adc_serial_port #(.RES(10)) dut10 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(smp[9:0]),
      .sdata_o(so[1]), .sdata_oe(oe[1]), .hold_o(hd[1]), .pdown_o(pd[1]));
   adc_serial_port #(.RES(8)) dut8 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(smp[7:0]),
      .sdata_o(so[2]), .sdata_oe(oe[2]), .hold_o(hd[2]), .pdown_o(pd[2]));

   function automatic int res_of(int i);
      return (i == 0) ? 12 : (i == 1) ? 10 : 8;
   endfunction

   function automatic logic exp_bit(int r, int k, logic [11:0] s);
      if (k < 2 || k >= 2 + r) return 1'b0;
      return s[r - 1 - (k - 2)];
   endfunction

   task automatic chk(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0b exp=%0b", what, act, exp);
      end
   endtask

   task automatic step();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic full_frame(input logic [11:0] s);
      smp  = s;
      cs_n = 1'b0;
      step();
      for (int i = 0; i < 3; i++) begin
         chk(oe[i], 1'b1, $sformatf("R1 oe res%0d", res_of(i)));
         chk(so[i], 1'b0, $sformatf("R1 lead zero res%0d", res_of(i)));
         chk(hd[i], 1'b1, $sformatf("R1 hold res%0d", res_of(i)));
         chk(pd[i], 1'b0, $sformatf("R8 pd clear res%0d", res_of(i)));
      end
      smp = ~s; // R9: late change must not reach the frame
      for (int k = 1; k <= 16; k++) begin
         sclk = 1'b0;
         step();
         for (int i = 0; i < 3; i++) begin
            int r = res_of(i);
            chk(oe[i], (k < 16), $sformatf("R4 oe res%0d fall %0d", r, k));
            if (k < 16)
               chk(so[i], exp_bit(r, k, s),
                   $sformatf("%s res%0d fall %0d s=%03h",
                             (k < 2 + r) ? "R2/R9 data" : "R3 trail", r, k, s));
            chk(hd[i], (k <= r + 1), $sformatf("R5 hold res%0d fall %0d", r, k));
         end
         sclk = 1'b1;
         step();
         for (int i = 0; i < 3; i++)
            chk(hd[i], (k < res_of(i) + 1),
                $sformatf("R5 hold res%0d rise %0d", res_of(i), k));
      end
      cs_n = 1'b1;
      step();
      for (int i = 0; i < 3; i++) begin
         chk(oe[i], 1'b0, $sformatf("R6 oe off res%0d", res_of(i)));
         chk(pd[i], 1'b0, $sformatf("R7 no pd after full res%0d", res_of(i)));
      end
   endtask

   task automatic abort_frame(input logic [11:0] s, input int cyc);
      smp  = s;
      cs_n = 1'b0;
      step();
      for (int k = 0; k < cyc; k++) begin
         sclk = 1'b0; step();
         sclk = 1'b1; step();
      end
      cs_n = 1'b1;
      step();
      for (int i = 0; i < 3; i++) begin
         int r = res_of(i);
         chk(oe[i], 1'b0, $sformatf("R6 abort oe res%0d cyc %0d", r, cyc));
         chk(hd[i], 1'b0, $sformatf("R7 abort hold res%0d cyc %0d", r, cyc));
         chk(pd[i], (r == 8 && cyc < r + 1),
             $sformatf("R7 pdown res%0d cyc %0d", r, cyc));
      end
      // R8: next chip-select fall clears power-down, and R6: slot restarts
      cs_n = 1'b0;
      step();
      for (int i = 0; i < 3; i++) begin
         chk(pd[i], 1'b0, $sformatf("R8 pd clear res%0d cyc %0d", res_of(i), cyc));
         chk(oe[i], 1'b1, $sformatf("R6 restart oe res%0d", res_of(i)));
      end
      sclk = 1'b0; step();
      for (int i = 0; i < 3; i++)
         chk(so[i], 1'b0, $sformatf("R6 restart second zero res%0d", res_of(i)));
      sclk = 1'b1; step();
      cs_n = 1'b1; step();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      for (int i = 0; i < 3; i++) begin
         chk(oe[i], 1'b0, "R6 reset oe");
         chk(hd[i], 1'b0, "R5 reset hold");
         chk(pd[i], 1'b0, "R8 reset pd");
      end
      full_frame(12'h000);
      full_frame(12'hFFF);
      full_frame(12'hAAA);
      full_frame(12'h555);
      for (int b = 0; b < 12; b++) full_frame(12'(1 << b));
      for (int j = 0; j < 6; j++) full_frame(12'((j * 1637 + 291) & 12'hFFF));
      for (int c = 0; c <= 16; c++) abort_frame(12'((c * 397 + 77) & 12'hFFF), c);
      full_frame(12'h3C5);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule